// File: doc/BRIEF.md
# DMA Port Address Generator

This block walks the address sequence of one side of a DMA channel, either the read side or the write side. A transfer is a block made of frames, and each frame is made of elements. The controller pulses `start` once to load a new block, then pulses `advance` each time the port has moved one element. After each advance the block presents the address of the next element and raises a one-cycle marker when a frame or the whole block has been consumed.

A two-bit mode selects one of four address patterns:
- a fixed address, for a peripheral data register;
- a linear walk by the element size;
- a walk with one signed element index;
- a walk with two signed indices, where the element index applies inside a frame and a separate frame index applies at each frame boundary. This last mode suits two-dimensional buffers such as image tiles.

All configuration is captured at `start`, so the controller may change its inputs while a block is running.

Top module: `dma_addr_walker`

## Requirements
- R1: A cycle with `start` high loads `addr` with `base_addr` and resets the element and frame counts. In the next cycle `eof` and `eob` are low.
- R2: In mode 2'b00, `addr` keeps the same value for every element of the block.
- R3: In mode 2'b01, each advance adds the element size to `addr`. The size is taken from `elem_size`: 2'b00 means 1 byte, 2'b01 means 2 bytes, and 2'b10 or 2'b11 mean 4 bytes.
- R4: In mode 2'b10, each advance adds (size + `elem_idx` − 1) to `addr`, with `elem_idx` a signed two's-complement value. This step is also used when moving from the last element of one frame to the first element of the next.
- R5: In mode 2'b11, an advance inside a frame adds (size + `elem_idx` − 1). An advance from the last element of a frame to the first element of the next adds (size + `frame_idx` − 1). Both indices are signed.
- R6: `eof` is high for exactly the cycle after an advance that consumed the last element of a frame. It is low after every other advance.
- R7: `eob` is high, together with `eof`, in the cycle after the advance that consumed the last element of the last frame. `addr` then keeps the address of that element.
- R8: Once a block has ended, further advances leave `addr` unchanged and raise no flag, until the next `start`.
- R9: A value of 0 in `elems_per_frame` or `frames_per_block` is handled the same as a value of 1.
- R10: After reset, `addr` is 0, both flags are low, and advances are ignored until the first `start`.
- R11: When `start` and `advance` are high in the same cycle, `start` wins: the address loads `base_addr` and no flag is raised. A `start` issued in the middle of a block restarts it.
- R12: Changes to the configuration inputs after `start` have no effect on the running block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load configuration and begin a block |
| advance | input | 1 | One element has been moved |
| mode | input | 2 | Addressing mode (00 fixed, 01 linear, 10 single index, 11 double index) |
| elem_size | input | 2 | Element size code (00=1, 01=2, 1x=4 bytes) |
| base_addr | input | ADDR_W | First address of the block |
| elem_idx | input | IDX_W | Signed element index |
| frame_idx | input | IDX_W | Signed frame index |
| elems_per_frame | input | CNT_W | Elements in each frame |
| frames_per_block | input | CNT_W | Frames in the block |
| addr | output | ADDR_W | Address of the current element |
| eof | output | 1 | One-cycle end-of-frame marker |
| eob | output | 1 | One-cycle end-of-block marker |

## Verification
Every result of this block is registered once, and nothing is pipelined behind that register. The loaded address after a `start`, the next address after an `advance`, and the `eof`/`eob` markers therefore all appear in the cycle immediately after the edge that sampled the stimulus. The bench drives each stimulus on a falling edge and holds it for one cycle. It samples on the following falling edge, half a cycle after the register has updated, so every flag is checked in exactly the one cycle it should be high. The cycle after that is covered by the next advance, or by an explicit idle check.

// File: rtl/dma_aw_pkg.sv
// Package: shared types and helpers for the DMA port address generator.
// Assumes: size codes 2'b10 and 2'b11 both mean a 4-byte element.
package dma_aw_pkg;

    typedef enum logic [1:0] {
        AM_FIXED  = 2'b00,
        AM_LINEAR = 2'b01,
        AM_SINGLE = 2'b10,
        AM_DOUBLE = 2'b11
    } amode_e;

    // Decode an element size code into a byte count.
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b00:   size_bytes = 3'd1;
            2'b01:   size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_aw_step.sv
// Module: dma_aw_step
// Computes the signed address step applied on one advance, from the mode,
// the element size and the two indices. frame_edge marks an advance that
// leaves the last element of a frame.
// Assumes: ADDR_W >= IDX_W. The result wraps modulo 2**ADDR_W.
module dma_aw_step
    import dma_aw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input  amode_e            mode,
    input  logic [1:0]        size_code,
    input  logic [IDX_W-1:0]  elem_idx,
    input  logic [IDX_W-1:0]  frame_idx,
    input  logic              frame_edge,
    output logic [ADDR_W-1:0] step
);
    localparam int EXT_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] elem_ext;
    logic [ADDR_W-1:0] frame_ext;
    logic [ADDR_W-1:0] size_ext;

    // Sign-extend both indices to the address width.
    generate
        if (EXT_W > 0) begin : g_ext
            assign elem_ext  = {{EXT_W{elem_idx[IDX_W-1]}},  elem_idx};
            assign frame_ext = {{EXT_W{frame_idx[IDX_W-1]}}, frame_idx};
        end else begin : g_same
            assign elem_ext  = elem_idx[ADDR_W-1:0];
            assign frame_ext = frame_idx[ADDR_W-1:0];
        end
    endgenerate

    assign size_ext = ADDR_W'(size_bytes(size_code));

    // Select the step for this mode and this position in the frame.
    always_comb begin
        case (mode)
            AM_FIXED:  step = '0;
            AM_LINEAR: step = size_ext;
            AM_SINGLE: step = size_ext + elem_ext - ADDR_W'(1);
            default:   step = frame_edge ? (size_ext + frame_ext - ADDR_W'(1))
                                         : (size_ext + elem_ext  - ADDR_W'(1));
        endcase
    end
endmodule

// File: rtl/dma_aw_counter.sv
// Module: dma_aw_counter
// A position counter that wraps at a limit. It flags the last position in
// the current cycle and returns to zero when bumped at the last position.
// Assumes: a limit of 0 is handled as 1. clear has priority over bump.
module dma_aw_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_plus;

    // Last position when the count plus one reaches the limit; 0 and 1 match at once.
    assign cnt_plus = {1'b0, cnt} + (CNT_W + 1)'(1);
    assign last     = (cnt_plus >= {1'b0, limit});

    // Count bumps and wrap to zero at the last position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (bump) begin
            cnt <= last ? '0 : cnt_plus[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/dma_addr_walker.sv
// Module: dma_addr_walker (top)
// Generates the element addresses of one DMA port over a block of frames in
// one of four modes. It pulses eof and eob one cycle after the advance that
// consumed the last element of a frame or of the block.
// Assumes: advance is a single-cycle strobe per element. All configuration
// is captured on start.
module dma_addr_walker
    import dma_aw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              advance,
    input  logic [1:0]        mode,
    input  logic [1:0]        elem_size,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  elem_idx,
    input  logic [IDX_W-1:0]  frame_idx,
    input  logic [CNT_W-1:0]  elems_per_frame,
    input  logic [CNT_W-1:0]  frames_per_block,
    output logic [ADDR_W-1:0] addr,
    output logic              eof,
    output logic              eob
);
    amode_e            cfg_mode;
    logic [1:0]        cfg_size;
    logic [IDX_W-1:0]  cfg_eidx;
    logic [IDX_W-1:0]  cfg_fidx;
    logic [CNT_W-1:0]  cfg_epf;
    logic [CNT_W-1:0]  cfg_fpb;
    logic              active;
    logic              adv_ok;
    logic              elem_last;
    logic              frame_last;
    logic              blk_end;
    logic [ADDR_W-1:0] step;

    // Capture the configuration of a block when it starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode <= AM_FIXED;
            cfg_size <= '0;
            cfg_eidx <= '0;
            cfg_fidx <= '0;
            cfg_epf  <= '0;
            cfg_fpb  <= '0;
        end else if (start) begin
            cfg_mode <= amode_e'(mode);
            cfg_size <= elem_size;
            cfg_eidx <= elem_idx;
            cfg_fidx <= frame_idx;
            cfg_epf  <= elems_per_frame;
            cfg_fpb  <= frames_per_block;
        end
    end

    assign adv_ok  = advance && active && !start;
    assign blk_end = adv_ok && elem_last && frame_last;

    dma_aw_counter #(.CNT_W(CNT_W)) u_elem_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .bump  (adv_ok),
        .limit (cfg_epf),
        .last  (elem_last)
    );

    dma_aw_counter #(.CNT_W(CNT_W)) u_frame_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .bump  (adv_ok && elem_last),
        .limit (cfg_fpb),
        .last  (frame_last)
    );

    dma_aw_step #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_step (
        .mode       (cfg_mode),
        .size_code  (cfg_size),
        .elem_idx   (cfg_eidx),
        .frame_idx  (cfg_fidx),
        .frame_edge (elem_last),
        .step       (step)
    );

    // Track whether a block is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
        end else if (blk_end) begin
            active <= 1'b0;
        end
    end

    // Load the base address on start and step it after each accepted advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (start) begin
            addr <= base_addr;
        end else if (adv_ok && !blk_end) begin
            addr <= addr + step;
        end
    end

    // Register the frame and block markers as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            eof <= 1'b0;
            eob <= 1'b0;
        end else begin
            eof <= adv_ok && elem_last;
            eob <= blk_end;
        end
    end
endmodule

// File: rtl/dma_aw_checker.sv
// Module: dma_aw_checker
// Temporal properties of the address generator, attached to the top by bind.
// Assumes: it sees the captured mode and size and the active state of the top.
module dma_aw_checker
    import dma_aw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              advance,
    input logic [ADDR_W-1:0] base_addr,
    input logic [ADDR_W-1:0] addr,
    input logic              eof,
    input logic              eob,
    input logic              active,
    input amode_e            cfg_mode,
    input logic [1:0]        cfg_size
);
    p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (addr == $past(base_addr)) && !eof && !eob);

    p_fixed_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start && cfg_mode == AM_FIXED) |=> $stable(addr));

    p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && advance && !start && cfg_mode == AM_LINEAR)
        |=> (eob || addr == $past(addr) + ADDR_W'(size_bytes($past(cfg_size)))));

    p_eof_after_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> $past(advance));

    p_eob_with_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eob |-> eof);

    p_idle_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> ($stable(addr) && !eof && !eob));
endmodule

bind dma_addr_walker dma_aw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .advance   (advance),
    .base_addr (base_addr),
    .addr      (addr),
    .eof       (eof),
    .eob       (eob),
    .active    (active),
    .cfg_mode  (cfg_mode),
    .cfg_size  (cfg_size)
);

// File: tb/dma_addr_walker_tb.sv
module dma_addr_walker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        advance = 1'b0;
    logic [1:0]  mode = '0;
    logic [1:0]  elem_size = '0;
    logic [31:0] base_addr = '0;
    logic [15:0] elem_idx = '0;
    logic [15:0] frame_idx = '0;
    logic [15:0] elems_per_frame = '0;
    logic [15:0] frames_per_block = '0;
    logic [31:0] addr;
    logic        eof;
    logic        eob;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_addr_walker u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .start            (start),
        .advance          (advance),
        .mode             (mode),
        .elem_size        (elem_size),
        .base_addr        (base_addr),
        .elem_idx         (elem_idx),
        .frame_idx        (frame_idx),
        .elems_per_frame  (elems_per_frame),
        .frames_per_block (frames_per_block),
        .addr             (addr),
        .eof              (eof),
        .eob              (eob)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int sz_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    // Drive a start for one cycle; sample on the next falling edge.
    task automatic do_start(input int m, input int sz, input logic [31:0] base,
                            input int ei, input int fi, input int ne, input int nf);
        @(negedge clk);
        mode = 2'(m); elem_size = 2'(sz); base_addr = base;
        elem_idx = 16'(ei); frame_idx = 16'(fi);
        elems_per_frame = 16'(ne); frames_per_block = 16'(nf);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_adv();
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    // Run a full block and compare every address and flag with the model.
    task automatic run_seq(input string tag, input int m, input int sz, input logic [31:0] base,
                           input int ei, input int fi, input int ne, input int nf);
        int ce, cf, stp;
        logic [31:0] exp;
        ce = (ne == 0) ? 1 : ne;
        cf = (nf == 0) ? 1 : nf;
        do_start(m, sz, base, ei, fi, ne, nf);
        exp = base;
        chk({tag, " R1 load"}, addr, exp);
        chk({tag, " R1 flags"}, {30'b0, eof, eob}, 32'd0);
        for (int f = 0; f < cf; f++) begin
            for (int e = 0; e < ce; e++) begin
                bit le, lf;
                le = (e == ce - 1);
                lf = (f == cf - 1);
                do_adv();
                case (m)
                    0: stp = 0;
                    1: stp = sz_of(sz);
                    2: stp = sz_of(sz) + ei - 1;
                    default: stp = le ? sz_of(sz) + fi - 1 : sz_of(sz) + ei - 1;
                endcase
                if (!(le && lf)) exp = exp + 32'(stp);
                chk({tag, " addr"}, addr, exp);
                chk({tag, " R6 eof"}, {31'b0, eof}, {31'b0, le});
                chk({tag, " R7 eob"}, {31'b0, eob}, {31'b0, le && lf});
            end
        end
    endtask

    task automatic t_reset();
        chk("R10 addr", addr, 32'd0);
        chk("R10 flags", {30'b0, eof, eob}, 32'd0);
        do_adv();
        do_adv();
        chk("R10 ignore addr", addr, 32'd0);
        chk("R10 ignore flags", {30'b0, eof, eob}, 32'd0);
    endtask

    task automatic t_fixed();
        run_seq("R2 fixed", 0, 2, 32'h4000_0010, 0, 0, 3, 2);
    endtask

    task automatic t_linear();
        run_seq("R3 size1", 1, 0, 32'h0000_1000, 0, 0, 3, 2);
        run_seq("R3 size2", 1, 1, 32'h0000_2000, 0, 0, 2, 2);
        run_seq("R3 size4", 1, 2, 32'h0000_3000, 0, 0, 4, 1);
        run_seq("R3 size4b", 1, 3, 32'hFFFF_FFF8, 0, 0, 3, 1);
    endtask

    task automatic t_single();
        run_seq("R4 pos", 2, 1, 32'h0000_0100, 5, 99, 3, 2);
        run_seq("R4 neg", 2, 2, 32'h0000_0400, -7, 50, 2, 3);
    endtask

    task automatic t_double();
        run_seq("R5 dbl", 3, 2, 32'h0001_0000, 1, -11, 4, 3);
        run_seq("R5 dbl2", 3, 0, 32'h0002_0000, 3, 20, 2, 2);
    endtask

    task automatic t_after_end();
        logic [31:0] held;
        run_seq("R8 pre", 1, 2, 32'h0000_5000, 0, 0, 2, 1);
        held = addr;
        for (int i = 0; i < 3; i++) begin
            do_adv();
            chk("R8 addr held", addr, held);
            chk("R8 no flags", {30'b0, eof, eob}, 32'd0);
        end
        do_start(1, 0, 32'h0000_6000, 0, 0, 2, 1);
        chk("R8 restart", addr, 32'h0000_6000);
        do_adv();
        chk("R8 restart step", addr, 32'h0000_6001);
    endtask

    task automatic t_zero_counts();
        run_seq("R9 zero", 1, 2, 32'h0000_7000, 0, 0, 0, 0);
        run_seq("R9 zero e", 3, 2, 32'h0000_7100, 5, 9, 0, 3);
    endtask

    task automatic t_start_prio();
        do_start(1, 2, 32'h0000_8000, 0, 0, 4, 1);
        do_adv();
        chk("R11 pre", addr, 32'h0000_8004);
        mode = 2'd1; elem_size = 2'd0; base_addr = 32'h0000_9000;
        elems_per_frame = 16'd1; frames_per_block = 16'd1;
        start = 1'b1; advance = 1'b1;
        @(negedge clk);
        start = 1'b0; advance = 1'b0;
        chk("R11 addr", addr, 32'h0000_9000);
        chk("R11 flags", {30'b0, eof, eob}, 32'd0);
        do_adv();
        chk("R11 restart end", {30'b0, eof, eob}, 32'd3);
    endtask

    task automatic t_cfg_hold();
        do_start(1, 2, 32'h0000_A000, 0, 0, 3, 1);
        mode = 2'd0; elem_size = 2'd0; elems_per_frame = 16'd1; base_addr = 32'h0;
        do_adv();
        chk("R12 step", addr, 32'h0000_A004);
        chk("R12 no eof", {31'b0, eof}, 32'd0);
        do_adv();
        do_adv();
        chk("R12 end", {30'b0, eof, eob}, 32'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fixed();
        t_linear();
        t_single();
        t_double();
        t_after_end();
        t_zero_counts();
        t_start_prio();
        t_cfg_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule